// File: doc/BRIEF.md
# Multi-Mode Prescaled Counter Timer

This block is a single up-counting timer built around three data registers: a running count, a compare value, and a shared register that serves as the first-phase match in pulse-width mode and as the capture store in the capture-type modes. A 4-bit mode field picks the behaviour and a 4-bit prescaler field sets how many timer clocks pass between count advances. The timer drives one output pin with selectable polarity and raises a sticky interrupt flag that an enable bit gates onto the interrupt line.

Software loads the three registers and the enable bit through simple write strobes, and reads them back on dedicated read ports. The event input triggers captures on either its rising or its falling edge, and a software strobe can force a capture directly.

Top module: `mmt_timer`

## Requirements
- R1: While reset is low, the count, compare and shared registers read 0, the enable reads 0, the interrupt flag reads 0 and the output equals the polarity input.
- R2: With prescaler field n from 0 to 11, the count advances once per 2^n clocks of enabled operation, and the first advance comes on the 2^n-th rising edge after the one that sets the enable. Field values 12 to 15 all divide by 4096.
- R3: In continuous mode (code 1), each advance adds 1 to the count. On an advance where the count equals the compare value, the count loads 1, the interrupt flag sets and the output state toggles.
- R4: One-shot mode (code 0) behaves like R3, and its compare match also clears the enable. The count then holds.
- R5: In pulse-width mode (code 3), the output state goes high on an advance where the count equals the shared register. On an advance where the count equals the compare value, the count loads 1, the output state goes low and the interrupt flag sets.
- R6: In capture mode (code 4) and capture/compare mode (code 7), while the timer is enabled, a selected event edge or a high software strobe copies the current count into the shared register and sets the interrupt flag. The selected edge is rising when the edge-select input is 0 and falling when it is 1, and the other edge does nothing. Code 4 counts without a wrap at the compare value. Code 7 loads 1 after a compare match, with no interrupt.
- R7: In compare mode (code 5), an advance where the count equals the compare value copies the count into the shared register, toggles the output state and sets the interrupt flag. The count keeps incrementing.
- R8: The output pin is the output state XOR the polarity input.
- R9: The interrupt flag stays set until a clear pulse arrives with no new event in the same cycle. The interrupt line is the flag AND the interrupt-enable input.
- R10: A count write loads the written value in place of any increment or reload in that cycle. Writing 0 to the enable stops the count.
- R11: Mode codes other than 0, 1, 3, 4, 5 and 7 hold the count. The event input and the software strobe have no effect outside codes 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Mode code |
| prescale | input | 4 | Prescaler select, divide by 2^n |
| polarity | input | 1 | Output inversion |
| evtIn | input | 1 | External event input |
| evtNegEdge | input | 1 | 1 selects the falling edge of evtIn |
| swCapture | input | 1 | Software capture strobe |
| irqEnable | input | 1 | Gates the flag onto irqOut |
| irqClr | input | 1 | Clears the interrupt flag |
| enWrEn | input | 1 | Enable write strobe |
| enWrData | input | 1 | Enable write value |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 32 | Count write value |
| cmpWrEn | input | 1 | Compare write strobe |
| cmpWrData | input | 32 | Compare write value |
| pwmWrEn | input | 1 | Shared register write strobe |
| pwmWrData | input | 32 | Shared register write value |
| timerOut | output | 1 | Timer output pin |
| irqFlag | output | 1 | Sticky interrupt flag |
| irqOut | output | 1 | Gated interrupt line |
| enRd | output | 1 | Enable state |
| cntRd | output | 32 | Count register |
| cmpRd | output | 32 | Compare register |
| pwmRd | output | 32 | Shared PWM/capture register |

## Verification
The assertions assume that the mode field is held steady while the counter runs. They also assume that a clear pulse never lands in the same cycle as a new interrupt event, since the set would win and a flag fall could then not be tied to a clear. The stimulus changes the mode only inside a reset and times every clear pulse after the enable has dropped or away from any match. In pulse-width mode the stimulus keeps the first-phase value below the compare value, so the two match points never coincide.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    MODE_ONESHOT    = 4'd0,
    MODE_CONT       = 4'd1,
    MODE_COUNTER    = 4'd2,
    MODE_PWM        = 4'd3,
    MODE_CAPTURE    = 4'd4,
    MODE_COMPARE    = 4'd5,
    MODE_GATED      = 4'd6,
    MODE_CAPCMP     = 4'd7,
    MODE_DUALEDGE   = 4'd8,
    MODE_INACTGATED = 4'd14
  } tmrMode_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cntInc;
    logic cntRestart;
    logic capture;
    logic outToggle;
    logic outSet;
    logic outClr;
  } dpStrobe_t;
endpackage

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
  import mmt_pkg::*;
#(
  parameter int PRESC_BITS = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] mode,
  input  logic [SEL_W-1:0] prescale,
  input  logic             evtIn,
  input  logic             evtNegEdge,
  input  logic             swCapture,
  input  logic             enWrEn,
  input  logic             enWrData,
  input  logic             irqClr,
  input  logic             cntEqCmp,
  input  logic             cntEqPwm,
  output dpStrobe_t        strobe,
  output logic             enState,
  output logic             irqFlag
);
  localparam int SHW = $clog2(PRESC_BITS + 1);

  logic [PRESC_BITS-1:0] presc;
  logic [PRESC_BITS-1:0] prescMask;
  logic [SHW-1:0]        shiftAmt;
  logic                  tick;
  logic                  evtPrev;
  logic                  hwEdge;
  logic                  capEvt;
  logic                  setIrq;
  logic                  stopReq;

  // Divider select, saturating at the widest setting
  always_comb begin
    shiftAmt  = (int'(prescale) > PRESC_BITS) ? SHW'(PRESC_BITS) : SHW'(prescale);
    prescMask = (PRESC_BITS'(1) << shiftAmt) - PRESC_BITS'(1);
  end

  assign tick   = enState && ((presc & prescMask) == prescMask);
  assign hwEdge = evtNegEdge ? (evtPrev && !evtIn) : (!evtPrev && evtIn);
  assign capEvt = enState && (hwEdge || swCapture);

  always_comb begin
    strobe  = '0;
    setIrq  = 1'b0;
    stopReq = 1'b0;
    case (mode)
      MODE_ONESHOT, MODE_CONT: begin
        if (tick) begin
          if (cntEqCmp) begin
            strobe.cntRestart = 1'b1;
            strobe.outToggle  = 1'b1;
            setIrq            = 1'b1;
            stopReq           = (mode == MODE_ONESHOT);
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      MODE_PWM: begin
        if (tick) begin
          if (cntEqCmp) begin
            strobe.cntRestart = 1'b1;
            strobe.outClr     = 1'b1;
            setIrq            = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
            strobe.outSet = cntEqPwm;
          end
        end
      end
      MODE_CAPTURE: begin
        strobe.cntInc  = tick;
        strobe.capture = capEvt;
        setIrq         = capEvt;
      end
      MODE_COMPARE: begin
        strobe.cntInc = tick;
        if (tick && cntEqCmp) begin
          strobe.capture   = 1'b1;
          strobe.outToggle = 1'b1;
          setIrq           = 1'b1;
        end
      end
      MODE_CAPCMP: begin
        if (tick) begin
          strobe.cntRestart = cntEqCmp;
          strobe.cntInc     = !cntEqCmp;
        end
        strobe.capture = capEvt;
        setIrq         = capEvt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc   <= '0;
      evtPrev <= 1'b0;
      enState <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      presc   <= enState ? presc + PRESC_BITS'(1) : '0;
      evtPrev <= evtIn;
      if (enWrEn)       enState <= enWrData;
      else if (stopReq) enState <= 1'b0;
      if (setIrq)       irqFlag <= 1'b1;
      else if (irqClr)  irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/mmt_dp.sv
module mmt_dp
  import mmt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic         polarity,
  input  logic         cntWrEn,
  input  logic [W-1:0] cntWrData,
  input  logic         cmpWrEn,
  input  logic [W-1:0] cmpWrData,
  input  logic         pwmWrEn,
  input  logic [W-1:0] pwmWrData,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp,
  output logic [W-1:0] pwm,
  output logic         cntEqCmp,
  output logic         cntEqPwm,
  output logic         timerOut
);
  logic outState;

  assign cntEqCmp = (cnt == cmp);
  assign cntEqPwm = (cnt == pwm);
  assign timerOut = outState ^ polarity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      cmp      <= '0;
      pwm      <= '0;
      outState <= 1'b0;
    end else begin
      if (cntWrEn)                cnt <= cntWrData;
      else if (strobe.cntRestart) cnt <= W'(1);
      else if (strobe.cntInc)     cnt <= cnt + W'(1);

      if (cmpWrEn) cmp <= cmpWrData;

      if (pwmWrEn)             pwm <= pwmWrData;
      else if (strobe.capture) pwm <= cnt;

      if (strobe.outClr)         outState <= 1'b0;
      else if (strobe.outSet)    outState <= 1'b1;
      else if (strobe.outToggle) outState <= !outState;
    end
  end
endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
  import mmt_pkg::*;
#(
  parameter int W          = 32,
  parameter int PRESC_BITS = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] mode,
  input  logic [SEL_W-1:0] prescale,
  input  logic             polarity,
  input  logic             evtIn,
  input  logic             evtNegEdge,
  input  logic             swCapture,
  input  logic             irqEnable,
  input  logic             irqClr,
  input  logic             enWrEn,
  input  logic             enWrData,
  input  logic             cntWrEn,
  input  logic [W-1:0]     cntWrData,
  input  logic             cmpWrEn,
  input  logic [W-1:0]     cmpWrData,
  input  logic             pwmWrEn,
  input  logic [W-1:0]     pwmWrData,
  output logic             timerOut,
  output logic             irqFlag,
  output logic             irqOut,
  output logic             enRd,
  output logic [W-1:0]     cntRd,
  output logic [W-1:0]     cmpRd,
  output logic [W-1:0]     pwmRd
);
  dpStrobe_t strobe;
  logic      cntEqCmp;
  logic      cntEqPwm;

  mmt_ctrl #(.PRESC_BITS(PRESC_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .prescale(prescale),
    .evtIn(evtIn), .evtNegEdge(evtNegEdge), .swCapture(swCapture),
    .enWrEn(enWrEn), .enWrData(enWrData), .irqClr(irqClr),
    .cntEqCmp(cntEqCmp), .cntEqPwm(cntEqPwm),
    .strobe(strobe), .enState(enRd), .irqFlag(irqFlag)
  );

  mmt_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .polarity(polarity),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .pwmWrEn(pwmWrEn), .pwmWrData(pwmWrData),
    .cnt(cntRd), .cmp(cmpRd), .pwm(pwmRd),
    .cntEqCmp(cntEqCmp), .cntEqPwm(cntEqPwm), .timerOut(timerOut)
  );

  assign irqOut = irqFlag && irqEnable;
endmodule

// File: rtl/mmt_timer_chk.sv
module mmt_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   mode,
  input logic         cntWrEn,
  input logic [W-1:0] cntWrData,
  input logic         pwmWrEn,
  input logic         enWrEn,
  input logic         irqClr,
  input logic [W-1:0] cntRd,
  input logic [W-1:0] pwmRd,
  input logic         enRd,
  input logic         irqFlag
);
  logic modeKnown;
  logic modeWraps;
  assign modeKnown = (mode == 4'd0) || (mode == 4'd1) || (mode == 4'd3) ||
                     (mode == 4'd4) || (mode == 4'd5) || (mode == 4'd7);
  assign modeWraps = (mode == 4'd0) || (mode == 4'd1) || (mode == 4'd3);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (cntRd == $past(cntWrData)));

  assert_hold_unknown_mode_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!modeKnown && !cntWrEn) |=> $stable(cntRd));

  assert_self_stop_oneshot_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(enRd) && !$past(enWrEn)) |-> ($past(mode) == 4'd0));

  assert_capture_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(pwmRd) && !$past(pwmWrEn)) |->
      (($past(mode) == 4'd4) || ($past(mode) == 4'd5) || ($past(mode) == 4'd7)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(irqClr));

  assert_step_or_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeWraps && !cntWrEn) |=>
      ((cntRd == $past(cntRd)) || (cntRd == $past(cntRd) + W'(1)) || (cntRd == W'(1))));
endmodule

bind mmt_timer mmt_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
  .pwmWrEn(pwmWrEn), .enWrEn(enWrEn), .irqClr(irqClr), .cntRd(cntRd),
  .pwmRd(pwmRd), .enRd(enRd), .irqFlag(irqFlag)
);

// File: tb/mmt_timer_tb.sv
module mmt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] mode = '0, prescale = '0;
  logic polarity = 0, evtIn = 0, evtNegEdge = 0, swCapture = 0, irqEnable = 0, irqClr = 0;
  logic enWrEn = 0, enWrData = 0, cntWrEn = 0, cmpWrEn = 0, pwmWrEn = 0;
  logic [W-1:0] cntWrData = '0, cmpWrData = '0, pwmWrData = '0;
  logic timerOut, irqFlag, irqOut, enRd;
  logic [W-1:0] cntRd, cmpRd, pwmRd;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmt_timer dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .prescale(prescale), .polarity(polarity),
    .evtIn(evtIn), .evtNegEdge(evtNegEdge), .swCapture(swCapture),
    .irqEnable(irqEnable), .irqClr(irqClr), .enWrEn(enWrEn), .enWrData(enWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .pwmWrEn(pwmWrEn), .pwmWrData(pwmWrData), .timerOut(timerOut), .irqFlag(irqFlag),
    .irqOut(irqOut), .enRd(enRd), .cntRd(cntRd), .cmpRd(cmpRd), .pwmRd(pwmRd)
  );

  typedef struct packed {
    int req; int md; int ps; int pol; int start; int cmpV; int pwmV; int k;
    int eCnt; int ePwm; int eOut; int eIrq; int eEn;
  } vec_t;

  // Expected values: advances after k edges = floor(k / 2^n)
  localparam vec_t VECS [18] = '{
    '{3, 1, 0, 0, 0,   5, 0,    3, 3, 0, 0, 0, 1},  // R3 plain increment
    '{3, 1, 0, 0, 0,   5, 0,    6, 1, 0, 1, 1, 1},  // R3 match reloads 1
    '{3, 1, 0, 0, 0,   5, 0,    7, 2, 0, 1, 1, 1},  // R3 after wrap
    '{2, 1, 2, 0, 0, 100, 0,   13, 3, 0, 0, 0, 1},  // R2 divide by 4
    '{2, 1, 1, 0, 0, 100, 0,    5, 2, 0, 0, 0, 1},  // R2 divide by 2
    '{2, 1, 11, 0, 0, 100, 0, 2048, 1, 0, 0, 0, 1}, // R2 divide by 2048
    '{2, 1, 15, 0, 0, 100, 0, 4095, 0, 0, 0, 0, 1}, // R2 code 15 = 4096
    '{2, 1, 15, 0, 0, 100, 0, 4096, 1, 0, 0, 0, 1}, // R2 code 15 = 4096
    '{4, 0, 0, 0, 0,   3, 0,   10, 1, 0, 1, 1, 0},  // R4 one-shot stops
    '{5, 3, 0, 0, 0,   6, 2,    2, 2, 2, 0, 0, 1},  // R5 first phase
    '{5, 3, 0, 0, 0,   6, 2,    3, 3, 2, 1, 0, 1},  // R5 second phase
    '{5, 3, 0, 0, 0,   6, 2,    7, 1, 2, 0, 1, 1},  // R5 period end
    '{5, 3, 0, 0, 0,   6, 2,    9, 3, 2, 1, 1, 1},  // R5 next period
    '{8, 3, 0, 1, 0,   6, 2,    3, 3, 2, 0, 0, 1},  // R8 inverted output
    '{7, 5, 0, 0, 0,   4, 0,    7, 7, 4, 1, 1, 1},  // R7 compare capture
    '{6, 7, 0, 0, 0,   3, 0,    5, 2, 0, 0, 0, 1},  // R6 code 7 wraps
    '{11, 2, 0, 0, 9,  3, 0,    5, 9, 0, 0, 0, 1},  // R11 code 2 holds
    '{11, 14, 0, 0, 9, 3, 0,    5, 9, 0, 0, 0, 1}   // R11 code 14 holds
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startRun(input int md, input int ps, input int pol, input int start,
                          input int cmpV, input int pwmV, input logic neg);
    @(negedge clk);
    rstN = 0; enWrEn = 0; irqClr = 0; swCapture = 0; evtIn = 0;
    mode = 4'(md); prescale = 4'(ps); polarity = pol[0]; evtNegEdge = neg;
    @(negedge clk);
    rstN = 1;
    cntWrEn = 1; cntWrData = W'(start);
    cmpWrEn = 1; cmpWrData = W'(cmpV);
    pwmWrEn = 1; pwmWrData = W'(pwmV);
    @(negedge clk);
    cntWrEn = 0; cmpWrEn = 0; pwmWrEn = 0;
    enWrEn = 1; enWrData = 1;
    @(negedge clk);
    enWrEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    polarity = 0;
    repeat (2) @(negedge clk);
    chk("R1 cnt", cntRd, 0);
    chk("R1 cmp", cmpRd, 0);
    chk("R1 pwm", pwmRd, 0);
    chk("R1 en", W'(enRd), 0);
    chk("R1 irq", W'(irqFlag), 0);
    chk("R1 out", W'(timerOut), 0);
    polarity = 1; #1;
    chk("R1 out pol", W'(timerOut), 1);
    polarity = 0;
    rstN = 1;

    // Table walk
    foreach (VECS[i]) begin
      startRun(VECS[i].md, VECS[i].ps, VECS[i].pol, VECS[i].start,
               VECS[i].cmpV, VECS[i].pwmV, 1'b0);
      repeat (VECS[i].k) @(negedge clk);
      chk($sformatf("R%0d v%0d cnt", VECS[i].req, i), cntRd, W'(VECS[i].eCnt));
      chk($sformatf("R%0d v%0d pwm", VECS[i].req, i), pwmRd, W'(VECS[i].ePwm));
      chk($sformatf("R%0d v%0d out", VECS[i].req, i), W'(timerOut), W'(VECS[i].eOut));
      chk($sformatf("R%0d v%0d irq", VECS[i].req, i), W'(irqFlag), W'(VECS[i].eIrq));
      chk($sformatf("R%0d v%0d en", VECS[i].req, i), W'(enRd), W'(VECS[i].eEn));
    end

    // R6 rising-edge capture, falling edge ignored
    startRun(4, 0, 0, 0, 0, 0, 1'b0);
    repeat (5) @(negedge clk);
    evtIn = 1;
    @(negedge clk);
    chk("R6 rise pwm", pwmRd, 5);
    chk("R6 rise irq", W'(irqFlag), 1);
    chk("R6 rise cnt", cntRd, 6);
    evtIn = 0; irqClr = 1;
    @(negedge clk);
    irqClr = 0;
    chk("R9 cleared", W'(irqFlag), 0);
    chk("R6 fall ignored", pwmRd, 5);

    // R6 falling-edge select
    startRun(4, 0, 0, 0, 0, 0, 1'b1);
    evtIn = 1;
    @(negedge clk);
    chk("R6 neg rise ignored irq", W'(irqFlag), 0);
    chk("R6 neg rise ignored pwm", pwmRd, 0);
    repeat (3) @(negedge clk);
    evtIn = 0;
    @(negedge clk);
    chk("R6 neg fall pwm", pwmRd, 4);
    chk("R6 neg fall irq", W'(irqFlag), 1);
    // R6 software strobe
    swCapture = 1;
    @(negedge clk);
    swCapture = 0;
    chk("R6 sw capture", pwmRd, 5);

    // R11 event and strobe ignored in continuous mode
    startRun(1, 0, 0, 0, 100, 32'h55, 1'b0);
    repeat (2) @(negedge clk);
    swCapture = 1; evtIn = 1;
    @(negedge clk);
    swCapture = 0;
    chk("R11 pwm kept", pwmRd, 32'h55);
    chk("R11 no irq", W'(irqFlag), 0);

    // R9 gating and clear
    startRun(0, 0, 0, 0, 2, 0, 1'b0);
    repeat (5) @(negedge clk);
    irqEnable = 0; #1;
    chk("R9 gated off", W'(irqOut), 0);
    irqEnable = 1; #1;
    chk("R9 gated on", W'(irqOut), 1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", W'(irqFlag), 1);
    irqClr = 1;
    @(negedge clk);
    irqClr = 0;
    chk("R9 clear", W'(irqFlag), 0);
    chk("R9 line low", W'(irqOut), 0);
    irqEnable = 0;

    // R10 write precedence and disable
    startRun(1, 0, 0, 0, 100, 0, 1'b0);
    repeat (3) @(negedge clk);
    cntWrEn = 1; cntWrData = 50;
    @(negedge clk);
    cntWrEn = 0;
    chk("R10 write wins", cntRd, 50);
    @(negedge clk);
    chk("R10 resumes", cntRd, 51);
    enWrEn = 1; enWrData = 0;
    @(negedge clk);
    enWrEn = 0;
    repeat (3) @(negedge clk);
    chk("R10 stopped cnt", cntRd, 52);
    chk("R10 stopped en", W'(enRd), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule